// File: doc/BRIEF.md
# Linear CCD Line-Transfer Timing Generator

This block drives the gates and clocks of a linear photodiode-array CCD imager. On each line trigger it moves charge into the horizontal shift register through a fixed, ordered handshake. The two horizontal phases stop first, with phase one held high and phase two held low. The transfer gate then rises, the photo gate pulses inside the transfer-gate window, and the transfer gate falls after the photo gate. An anti-blooming pulse follows the photo-gate fall. After the handshake, the two phases alternate without overlap to shift out a programmed number of pixels. A reset-gate pulse and a pixel-valid strobe are produced for every pixel.

Every delay and pulse width is a count of reference-clock cycles, taken from a configuration input. Each count is raised to a minimum that is derived from the reference-clock period and an allowance for gate edge time. The configuration is captured when a line starts, so the host may change it while a line is running. All outputs leave flops, which gives every output the same latency.

Top module: `ccd_line_timer`

## Requirements
- R1: While reset is active and directly after it, `phi1` is 1. `phi2`, `tgGate`, `pgGate`, `abGate`, `rgGate`, `busy`, `lineDone` and `pixValid` are all 0.
- R2: A `lineTrig` pulse received while idle starts a line. `busy` goes high and stays high until the cycle after `lineDone`. Throughout the transfer, `phi1` stays 1 and `phi2` stays 0.
- R3: Transfer order and timing, measured in cycles. `tgGate` rises T1 cycles after `busy` rises. `pgGate` rises T2 cycles after `tgGate` rises. `pgGate` stays high for T3 cycles. `tgGate` falls T4 cycles after `pgGate` falls. Here T1..T4 are the effective values of `cfgTgDelay`, `cfgTgToPg`, `cfgPgWidth` and `cfgPgToTg`.
- R4: Whenever `tgGate` or `pgGate` is high, `phi1` is 1 and `phi2` is 0. `pgGate` is high only while `tgGate` is high. Every `tgGate` pulse lasts at least 16 cycles.
- R5: `abGate` rises A1 cycles after `pgGate` falls and stays high for A2 cycles. A1 and A2 are the effective `cfgAbDelay` and `cfgAbWidth`.
- R6: Readout starts when `tgGate` falls, and `phi1` falls in that same cycle. Each pixel then runs in this order: one cycle with both phases low, `phi2` high for H cycles, one cycle with both phases low, and `phi1` high for H cycles. H is the effective `cfgPhaseHigh`. The phases never overlap. Exactly `cfgPixCount` pixels are shifted out, and `phi1` is left high at the end.
- R7: `rgGate` is high for one cycle, in the first `phi2`-high cycle of each pixel, and never while `phi2` is low. `pixValid` is high for one cycle, in the gap that follows each `phi2` pulse.
- R8: Let R be the cycle after the last pixel's `phi1` phase, or the `tgGate` fall cycle when the pixel count is 0. Let E be the `abGate` fall cycle. `lineDone` pulses for exactly one cycle, at max(R, E+1).
- R9: A pixel count of 0 produces no `phi2`, `rgGate` or `pixValid` pulse, and `phi1` stays high for the whole line.
- R10: A timing value below its minimum is raised to that minimum. With the defaults (8 ns reference clock, 20 ns edge allowance) the minimums are: T1 3, T2 3, T3 16, T4 4, A1 4, A2 3 and H 3 cycles.
- R11: `lineTrig` is ignored while `busy` is high. All configuration inputs are captured at the accepted trigger, so a change made during a line has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineTrig | input | 1 | Line start request |
| cfgPixCount | input | PIX_W | Pixels per line |
| cfgTgDelay | input | CNT_W | Cycles from clock park to transfer-gate rise |
| cfgTgToPg | input | CNT_W | Cycles from transfer-gate rise to photo-gate rise |
| cfgPgWidth | input | CNT_W | Photo-gate high cycles |
| cfgPgToTg | input | CNT_W | Cycles from photo-gate fall to transfer-gate fall |
| cfgAbDelay | input | CNT_W | Cycles from photo-gate fall to anti-blooming rise |
| cfgAbWidth | input | CNT_W | Anti-blooming high cycles |
| cfgPhaseHigh | input | CNT_W | High cycles of each horizontal phase pulse |
| phi1 | output | 1 | Horizontal phase one |
| phi2 | output | 1 | Horizontal phase two |
| tgGate | output | 1 | Transfer gate |
| pgGate | output | 1 | Photo gate |
| abGate | output | 1 | Anti-blooming gate |
| rgGate | output | 1 | Per-pixel reset gate |
| busy | output | 1 | Line in progress |
| lineDone | output | 1 | One-cycle end-of-line pulse |
| pixValid | output | 1 | One-cycle strobe per pixel |

## Verification
The assertions cover the properties that must hold in every cycle. The clocks stay parked while either gate is open, and the photo gate stays inside the transfer gate. The two phases never overlap, and the reset gate fires only during phase two. A counter confirms the minimum transfer-gate width, and `lineDone` never lasts more than one cycle. Further checks confirm that no pixel is shifted beyond the programmed count. The directed scenarios cover what no single-cycle property can show:
- the exact edge-to-edge delays for several settings;
- the clamping of zero settings;
- the choice between readout end and anti-blooming end for the `lineDone` cycle;
- the zero-pixel line;
- a retrigger and configuration change during a line, which must have no effect.

// File: rtl/ccd_timer_pkg.sv
package ccd_timer_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_TGDLY, S_TGPG, S_PGON, S_PGTG,
    S_GAPA, S_PH2, S_GAPB, S_PH1, S_WAITAB, S_DONE
  } state_t;

  typedef enum logic [1:0] {T_TGPG, T_PGON, T_PGTG, T_PHASE} tsel_t;

  typedef enum logic [1:0] {AB_IDLE, AB_DLY, AB_ON} abph_t;

  // Shadow register slots
  localparam int CFG_TGPG  = 0;
  localparam int CFG_PGON  = 1;
  localparam int CFG_PGTG  = 2;
  localparam int CFG_ABDLY = 3;
  localparam int CFG_ABON  = 4;
  localparam int CFG_PHASE = 5;
  localparam int NCFG      = 6;

  // Strobes from control to datapath
  typedef struct packed {
    logic  latch;
    logic  tmrLoad;
    tsel_t tmrSel;
    logic  pixDec;
    logic  abStart;
  } strobe_t;

  // Decoded output levels, registered in the datapath
  typedef struct packed {
    logic phi1;
    logic phi2;
    logic tg;
    logic pg;
    logic rg;
    logic pixValid;
    logic busy;
    logic lineDone;
  } level_t;

  function automatic int minCycles(int ns, int refNs, int edgeNs);
    return (ns + edgeNs) / refNs + 1;
  endfunction

endpackage

// File: rtl/ccd_timer_ctrl.sv
module ccd_timer_ctrl
  import ccd_timer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    lineTrig,
  input  logic    tmrDone,
  input  logic    pixLast,
  input  logic    pixZero,
  input  logic    abBusy,
  output strobe_t st,
  output level_t  lev
);

  state_t stateQ, stateN;
  logic   firstQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      firstQ <= 1'b0;
    end else begin
      stateQ <= stateN;
      firstQ <= (stateN != stateQ);
    end
  end

  always_comb begin
    stateN = stateQ;
    st     = '0;
    unique case (stateQ)
      S_IDLE: if (lineTrig) begin
        st.latch = 1'b1;
        stateN   = S_TGDLY;
      end
      S_TGDLY: if (tmrDone) begin
        st.tmrLoad = 1'b1;
        st.tmrSel  = T_TGPG;
        stateN     = S_TGPG;
      end
      S_TGPG: if (tmrDone) begin
        st.tmrLoad = 1'b1;
        st.tmrSel  = T_PGON;
        stateN     = S_PGON;
      end
      S_PGON: if (tmrDone) begin
        st.tmrLoad = 1'b1;
        st.tmrSel  = T_PGTG;
        st.abStart = 1'b1;
        stateN     = S_PGTG;
      end
      S_PGTG: if (tmrDone) begin
        if (pixZero) stateN = abBusy ? S_WAITAB : S_DONE;
        else         stateN = S_GAPA;
      end
      S_GAPA: begin
        st.tmrLoad = 1'b1;
        st.tmrSel  = T_PHASE;
        stateN     = S_PH2;
      end
      S_PH2: if (tmrDone) stateN = S_GAPB;
      S_GAPB: begin
        st.tmrLoad = 1'b1;
        st.tmrSel  = T_PHASE;
        stateN     = S_PH1;
      end
      S_PH1: if (tmrDone) begin
        st.pixDec = 1'b1;
        if (pixLast) stateN = abBusy ? S_WAITAB : S_DONE;
        else         stateN = S_GAPA;
      end
      S_WAITAB: if (!abBusy) stateN = S_DONE;
      S_DONE:   stateN = S_IDLE;
      default:  stateN = S_IDLE;
    endcase
  end

  always_comb begin
    lev          = '0;
    lev.phi1     = !(stateQ inside {S_GAPA, S_PH2, S_GAPB});
    lev.phi2     = (stateQ == S_PH2);
    lev.tg       = (stateQ inside {S_TGPG, S_PGON, S_PGTG});
    lev.pg       = (stateQ == S_PGON);
    lev.rg       = (stateQ == S_PH2) && firstQ;
    lev.pixValid = (stateQ == S_GAPB);
    lev.busy     = (stateQ != S_IDLE);
    lev.lineDone = (stateQ == S_DONE);
  end

endmodule

// File: rtl/ccd_timer_dp.sv
module ccd_timer_dp
  import ccd_timer_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int PIX_W   = 12,
  parameter int REF_NS  = 8,
  parameter int EDGE_NS = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  level_t           lev,
  input  logic [PIX_W-1:0] cfgPixCount,
  input  logic [CNT_W-1:0] cfgTgDelay,
  input  logic [CNT_W-1:0] cfgTgToPg,
  input  logic [CNT_W-1:0] cfgPgWidth,
  input  logic [CNT_W-1:0] cfgPgToTg,
  input  logic [CNT_W-1:0] cfgAbDelay,
  input  logic [CNT_W-1:0] cfgAbWidth,
  input  logic [CNT_W-1:0] cfgPhaseHigh,
  output logic             tmrDone,
  output logic             pixLast,
  output logic             pixZero,
  output logic             abBusy,
  output logic             phi1Q,
  output logic             phi2Q,
  output logic             tgQ,
  output logic             pgQ,
  output logic             abQ,
  output logic             rgQ,
  output logic             busyQ,
  output logic             doneQ,
  output logic             pvQ
);

  localparam int MIN_TGDLY   = minCycles(0, REF_NS, EDGE_NS);
  localparam int MIN_TGWIDTH = minCycles(100, REF_NS, EDGE_NS);
  localparam int MIN_NS [NCFG] = '{0, 100, 5, 5, 0, 0};

  function automatic logic [CNT_W-1:0] clampUp(logic [CNT_W-1:0] v, int m);
    return (int'(v) < m) ? CNT_W'(m) : v;
  endfunction

  logic [CNT_W-1:0] cfgRaw [NCFG];
  logic [CNT_W-1:0] shadow [NCFG];
  logic [CNT_W-1:0] tmrCnt, loadVal, abCnt;
  logic [PIX_W-1:0] pixLeft;
  abph_t            abPh;

  assign cfgRaw[CFG_TGPG]  = cfgTgToPg;
  assign cfgRaw[CFG_PGON]  = cfgPgWidth;
  assign cfgRaw[CFG_PGTG]  = cfgPgToTg;
  assign cfgRaw[CFG_ABDLY] = cfgAbDelay;
  assign cfgRaw[CFG_ABON]  = cfgAbWidth;
  assign cfgRaw[CFG_PHASE] = cfgPhaseHigh;

  // Captured, clamped configuration
  for (genvar g = 0; g < NCFG; g++) begin : gShadow
    localparam int MINC = minCycles(MIN_NS[g], REF_NS, EDGE_NS);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         shadow[g] <= CNT_W'(MINC);
      else if (st.latch) shadow[g] <= clampUp(cfgRaw[g], MINC);
    end
  end

  always_comb begin
    unique case (st.tmrSel)
      T_TGPG:  loadVal = shadow[CFG_TGPG];
      T_PGON:  loadVal = shadow[CFG_PGON];
      T_PGTG:  loadVal = shadow[CFG_PGTG];
      default: loadVal = shadow[CFG_PHASE];
    endcase
  end

  // Interval timer for the sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tmrCnt <= '0;
    else if (st.latch)        tmrCnt <= clampUp(cfgTgDelay, MIN_TGDLY) - 1'b1;
    else if (st.tmrLoad)      tmrCnt <= loadVal - 1'b1;
    else if (tmrCnt != '0)    tmrCnt <= tmrCnt - 1'b1;
  end
  assign tmrDone = (tmrCnt == '0);

  // Pixel counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         pixLeft <= '0;
    else if (st.latch)                 pixLeft <= cfgPixCount;
    else if (st.pixDec && pixLeft != '0) pixLeft <= pixLeft - 1'b1;
  end
  assign pixLast = (pixLeft == PIX_W'(1));
  assign pixZero = (pixLeft == '0);

  // Anti-blooming timer, runs beside the sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abPh  <= AB_IDLE;
      abCnt <= '0;
    end else if (st.abStart) begin
      abPh  <= AB_DLY;
      abCnt <= shadow[CFG_ABDLY] - 1'b1;
    end else if (abCnt != '0) begin
      abCnt <= abCnt - 1'b1;
    end else if (abPh == AB_DLY) begin
      abPh  <= AB_ON;
      abCnt <= shadow[CFG_ABON] - 1'b1;
    end else begin
      abPh  <= AB_IDLE;
    end
  end
  assign abBusy = (abPh != AB_IDLE);

  // Output flops
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phi1Q <= 1'b1;
      {phi2Q, tgQ, pgQ, abQ, rgQ, busyQ, doneQ, pvQ} <= '0;
    end else begin
      phi1Q <= lev.phi1;
      phi2Q <= lev.phi2;
      tgQ   <= lev.tg;
      pgQ   <= lev.pg;
      abQ   <= (abPh == AB_ON);
      rgQ   <= lev.rg;
      busyQ <= lev.busy;
      doneQ <= lev.lineDone;
      pvQ   <= lev.pixValid;
    end
  end

  // Checks on the driven waveforms
  logic [CNT_W-1:0] tgRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tgRun <= '0;
    else if (!tgQ)            tgRun <= '0;
    else if (tgRun != '1)     tgRun <= tgRun + 1'b1;
  end

  a_r4_parked_in_transfer: assert property (@(posedge clk) disable iff (!rstN)
    (tgQ || pgQ) |-> (phi1Q && !phi2Q));
  a_r4_pg_inside_tg: assert property (@(posedge clk) disable iff (!rstN)
    pgQ |-> tgQ);
  a_r4_tg_min_width: assert property (@(posedge clk) disable iff (!rstN)
    (tgQ && !lev.tg) |-> (int'(tgRun) >= MIN_TGWIDTH - 1));
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(phi1Q && phi2Q));
  a_r6_no_extra_pixel: assert property (@(posedge clk) disable iff (!rstN)
    st.pixDec |-> (pixLeft != '0));
  a_r7_rg_in_phi2: assert property (@(posedge clk) disable iff (!rstN)
    rgQ |-> phi2Q);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_timer_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int PIX_W   = 12,
  parameter int REF_NS  = 8,
  parameter int EDGE_NS = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineTrig,
  input  logic [PIX_W-1:0] cfgPixCount,
  input  logic [CNT_W-1:0] cfgTgDelay,
  input  logic [CNT_W-1:0] cfgTgToPg,
  input  logic [CNT_W-1:0] cfgPgWidth,
  input  logic [CNT_W-1:0] cfgPgToTg,
  input  logic [CNT_W-1:0] cfgAbDelay,
  input  logic [CNT_W-1:0] cfgAbWidth,
  input  logic [CNT_W-1:0] cfgPhaseHigh,
  output logic             phi1,
  output logic             phi2,
  output logic             tgGate,
  output logic             pgGate,
  output logic             abGate,
  output logic             rgGate,
  output logic             busy,
  output logic             lineDone,
  output logic             pixValid
);

  strobe_t st;
  level_t  lev;
  logic    tmrDone, pixLast, pixZero, abBusy;

  ccd_timer_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .lineTrig(lineTrig),
    .tmrDone (tmrDone),
    .pixLast (pixLast),
    .pixZero (pixZero),
    .abBusy  (abBusy),
    .st      (st),
    .lev     (lev)
  );

  ccd_timer_dp #(
    .CNT_W  (CNT_W),
    .PIX_W  (PIX_W),
    .REF_NS (REF_NS),
    .EDGE_NS(EDGE_NS)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .lev         (lev),
    .cfgPixCount (cfgPixCount),
    .cfgTgDelay  (cfgTgDelay),
    .cfgTgToPg   (cfgTgToPg),
    .cfgPgWidth  (cfgPgWidth),
    .cfgPgToTg   (cfgPgToTg),
    .cfgAbDelay  (cfgAbDelay),
    .cfgAbWidth  (cfgAbWidth),
    .cfgPhaseHigh(cfgPhaseHigh),
    .tmrDone     (tmrDone),
    .pixLast     (pixLast),
    .pixZero     (pixZero),
    .abBusy      (abBusy),
    .phi1Q       (phi1),
    .phi2Q       (phi2),
    .tgQ         (tgGate),
    .pgQ         (pgGate),
    .abQ         (abGate),
    .rgQ         (rgGate),
    .busyQ       (busy),
    .doneQ       (lineDone),
    .pvQ         (pixValid)
  );

endmodule

// File: tb/sim_ccd_line_timer.sv
module sim_ccd_line_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineTrig = 1'b0;
  logic [11:0] cfgPixCount = '0;
  logic [9:0]  cfgTgDelay = '0, cfgTgToPg = '0, cfgPgWidth = '0, cfgPgToTg = '0;
  logic [9:0]  cfgAbDelay = '0, cfgAbWidth = '0, cfgPhaseHigh = '0;
  logic phi1, phi2, tgGate, pgGate, abGate, rgGate, busy, lineDone, pixValid;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ccd_line_timer u0 (
    .clk(clk), .rstN(rstN), .lineTrig(lineTrig),
    .cfgPixCount(cfgPixCount), .cfgTgDelay(cfgTgDelay), .cfgTgToPg(cfgTgToPg),
    .cfgPgWidth(cfgPgWidth), .cfgPgToTg(cfgPgToTg), .cfgAbDelay(cfgAbDelay),
    .cfgAbWidth(cfgAbWidth), .cfgPhaseHigh(cfgPhaseHigh),
    .phi1(phi1), .phi2(phi2), .tgGate(tgGate), .pgGate(pgGate), .abGate(abGate),
    .rgGate(rgGate), .busy(busy), .lineDone(lineDone), .pixValid(pixValid)
  );

  // Observed event cycles for one line
  int bRise, bFall, nBusyRise, tgR, tgF, nTgR, pgR, pgF, abR, abF;
  int p1F, p2R, p2F, nP2, nRg, nPv, ldC, nLd, overl, rgBad, parkBad;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runLine(int d1, int d2, int d3, int d4, int d5, int d6, int h,
                         int n, int retrigAt, int tail);
    logic pPhi1, pPhi2, pTg, pPg, pAb, pBusy;
    int tailCnt;
    cfgTgDelay = 10'(d1); cfgTgToPg = 10'(d2); cfgPgWidth = 10'(d3);
    cfgPgToTg = 10'(d4); cfgAbDelay = 10'(d5); cfgAbWidth = 10'(d6);
    cfgPhaseHigh = 10'(h); cfgPixCount = 12'(n);
    bRise = -1; bFall = -1; nBusyRise = 0; tgR = -1; tgF = -1; nTgR = 0;
    pgR = -1; pgF = -1; abR = -1; abF = -1; p1F = -1; p2R = -1; p2F = -1;
    nP2 = 0; nRg = 0; nPv = 0; ldC = -1; nLd = 0; overl = 0; rgBad = 0; parkBad = 0;
    @(negedge clk);
    pPhi1 = phi1; pPhi2 = phi2; pTg = tgGate; pPg = pgGate; pAb = abGate; pBusy = busy;
    lineTrig = 1'b1;
    tailCnt = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (i == 0) lineTrig = 1'b0;
      if (i == retrigAt) begin
        lineTrig = 1'b1; cfgPixCount = 12'd9; cfgPhaseHigh = 10'd7; cfgTgDelay = 10'd9;
      end
      if (i == retrigAt + 1) lineTrig = 1'b0;
      if (busy && !pBusy) begin nBusyRise++; if (bRise < 0) bRise = i; end
      if (!busy && pBusy && bFall < 0) bFall = i;
      if (tgGate && !pTg) begin nTgR++; if (tgR < 0) tgR = i; end
      if (!tgGate && pTg && tgF < 0) tgF = i;
      if (pgGate && !pPg && pgR < 0) pgR = i;
      if (!pgGate && pPg && pgF < 0) pgF = i;
      if (abGate && !pAb && abR < 0) abR = i;
      if (!abGate && pAb && abF < 0) abF = i;
      if (!phi1 && pPhi1 && p1F < 0) p1F = i;
      if (phi2 && !pPhi2) begin nP2++; if (p2R < 0) p2R = i; end
      if (!phi2 && pPhi2 && p2F < 0) p2F = i;
      if (rgGate) nRg++;
      if (pixValid) nPv++;
      if (lineDone) begin nLd++; if (ldC < 0) ldC = i; end
      if (phi1 && phi2) overl++;
      if (rgGate && !phi2) rgBad++;
      if ((tgGate || pgGate) && !(phi1 && !phi2)) parkBad++;
      pPhi1 = phi1; pPhi2 = phi2; pTg = tgGate; pPg = pgGate; pAb = abGate; pBusy = busy;
      if (ldC >= 0) begin
        tailCnt++;
        if (tailCnt > tail) break;
      end
    end
  endtask

  // Compare one observed line against the requirement formulas
  task automatic checkLine(string nm, int e1, int e2, int e3, int e4, int e5, int e6,
                           int h, int n);
    int expR, expLd;
    chk(nBusyRise == 1, {nm, " R2 busy rises once"}, nBusyRise, 1);
    chk(parkBad == 0, {nm, " R2/R4 clocks parked during transfer"}, parkBad, 0);
    chk(tgR - bRise == e1, {nm, " R3 tg rise delay"}, tgR - bRise, e1);
    chk(pgR - tgR == e2, {nm, " R3 pg rise delay"}, pgR - tgR, e2);
    chk(pgF - pgR == e3, {nm, " R3 pg width"}, pgF - pgR, e3);
    chk(tgF - pgF == e4, {nm, " R3 tg fall delay"}, tgF - pgF, e4);
    chk(abR - pgF == e5, {nm, " R5 ab delay"}, abR - pgF, e5);
    chk(abF - abR == e6, {nm, " R5 ab width"}, abF - abR, e6);
    chk(nP2 == n, {nm, " R6 pixel count"}, nP2, n);
    chk(overl == 0, {nm, " R6 phase overlap"}, overl, 0);
    if (n > 0) begin
      chk(p1F == tgF, {nm, " R6 phi1 falls with tg"}, p1F, tgF);
      chk(p2R - p1F == 1, {nm, " R6 gap before phi2"}, p2R - p1F, 1);
      chk(p2F - p2R == h, {nm, " R6 phi2 width"}, p2F - p2R, h);
    end else begin
      chk(p1F == -1, {nm, " R9 phi1 stays high"}, p1F, -1);
    end
    chk(nRg == n, {nm, " R7 reset gate count"}, nRg, n);
    chk(rgBad == 0, {nm, " R7 rg outside phi2"}, rgBad, 0);
    chk(nPv == n, {nm, " R7 pixValid count"}, nPv, n);
    expR  = tgF + n * (2 * h + 2);
    expLd = (expR > abF + 1) ? expR : abF + 1;
    chk(ldC == expLd, {nm, " R8 lineDone cycle"}, ldC, expLd);
    chk(nLd == 1, {nm, " R8 lineDone single pulse"}, nLd, 1);
    chk(bFall == ldC + 1, {nm, " R2 busy falls after lineDone"}, bFall, ldC + 1);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(phi1 == 1'b1, "R1 phi1 high in reset", int'(phi1), 1);
    chk({phi2, tgGate, pgGate, abGate, rgGate, busy, lineDone, pixValid} == 8'h00,
        "R1 other outputs low in reset",
        int'({phi2, tgGate, pgGate, abGate, rgGate, busy, lineDone, pixValid}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(phi1 == 1'b1 && !busy && !tgGate, "R1 idle after reset",
        int'({phi1, busy, tgGate}), 4);
  endtask

  task automatic testNormal();
    runLine(5, 4, 20, 6, 5, 40, 4, 5, -10, 3);
    checkLine("normal", 5, 4, 20, 6, 5, 40, 4, 5);
  endtask

  task automatic testLongAb();
    // anti-blooming outlasts readout: lineDone waits for it (R8)
    runLine(3, 3, 16, 4, 6, 200, 3, 3, -10, 3);
    checkLine("longab", 3, 3, 16, 4, 6, 200, 3, 3);
    chk(ldC == abF + 1, "R8 lineDone follows ab end", ldC, abF + 1);
  endtask

  task automatic testZeroPix();
    runLine(4, 5, 18, 5, 4, 3, 3, 0, -10, 3);
    checkLine("zeropix R9", 4, 5, 18, 5, 4, 3, 3, 0);
    chk(nP2 == 0 && nPv == 0, "R9 no pixel activity", nP2 + nPv, 0);
  endtask

  task automatic testClamp();
    runLine(0, 0, 0, 0, 0, 0, 0, 2, -10, 3);
    checkLine("clamp R10", 3, 3, 16, 4, 4, 3, 3, 2);
  endtask

  task automatic testRetrig();
    // retrigger and config change at cycle 30, during the transfer (R11)
    runLine(5, 4, 20, 6, 5, 10, 4, 4, 30, 60);
    checkLine("retrig R11", 5, 4, 20, 6, 5, 10, 4, 4);
    chk(nTgR == 1, "R11 no second transfer", nTgR, 1);
    chk(busy == 1'b0, "R11 idle after ignored trigger", int'(busy), 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testNormal();
    testLongAb();
    testZeroPix();
    testClamp();
    testRetrig();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule